// File: doc/BRIEF.md
# Line Oscillator Calibration and Gain Sequencer

This block is the digital control that sits around a horizontal line phase-locked loop. A free-running oscillator, which this block sees only as a one-cycle tick input, is divided down by 64 to make the loop's own line-rate pulse. The number of oscillator ticks that fall between two reference line pulses is compared with 64. A saturating trim counter moves up when the oscillator is slow and down when it is fast, and its value drives the frequency-correction converter.

The trim counter only moves during a calibration window or while the loop reports itself out of lock. The calibration window lasts two reference lines, opens at reset and reopens on every channel-change request. While the window is open the phase detector is disconnected. The block also sets the phase-detector gain. The host chooses a normal gain, and the block forces maximum gain for eleven lines after each vertical sync ends.

Two flags go to the host and are refreshed once per loop line. One reports that incoming horizontal sync did not coincide with the loop's line pulse. The other reports that no flyback pulse was seen during the line. The block also provides a selectable twice-line-rate or line-rate output pulse.

Top module: `lineosc_top`

## Requirements
- R1: The loop divider counts oscillator ticks modulo 64, and a line-rate event occurs on the tick that takes the count from 63 back to 0. After reset the count is 0.
- R2: `hOut` pulses for one cycle, in the cycle after each tick that ends a half line (count 31 or 63). This holds when `halfRate` is 0, giving twice the line rate. When `halfRate` is 1, `hOut` pulses only after the tick at count 63, giving the line rate.
- R3: On each `refLine` pulse after the first one since reset, N is the number of ticks since the previous `refLine`. If calibration is enabled, `trimWord` rises by 1 when N < 64, falls by 1 when N > 64, and holds when N = 64. The new value is visible the cycle after the pulse.
- R4: `trimWord` saturates at 0 and at its all-ones code and never wraps.
- R5: After reset, `pdEnable` is 0 until two `refLine` pulses have been seen. Calibration is enabled while `pdEnable` is 0.
- R6: A `chanChange` pulse drives `pdEnable` to 0 from the next cycle. `pdEnable` stays 0 for the next two `refLine` pulses, and calibration is enabled during that time.
- R7: When `pdEnable` is 1 and `notLocked` is 0, `trimWord` does not change, whatever the tick count.
- R8: At each line-rate event, `notLocked` is set to 0 if `hSync` was high in some cycle whose divider count was in 60..63 during the line just ended. Otherwise `notLocked` is set to 1.
- R9: Outside a boost, `pdGain` equals the host's `gainSel`.
- R10: In the cycle after `vSync` falls, `pdGain` becomes 2'b11 and holds that value until 11 further `refLine` pulses have been seen. It then returns to `gainSel`.
- R11: At each line-rate event, `flybackMissing` is set to 1 if `flyback` was never high during the line just ended, and to 0 otherwise.
- R12: Reset gives `trimWord` = 32 (mid-code), `pdEnable` = 0, `notLocked` = 1, `flybackMissing` = 0, `hOut` = 0 and `pdGain` = `gainSel`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| oscTick | input | 1 | One-cycle tick from the line oscillator |
| refLine | input | 1 | One-cycle reference line pulse from the subcarrier divider |
| hSync | input | 1 | Incoming horizontal sync |
| flyback | input | 1 | Line flyback pulse |
| vSync | input | 1 | Vertical sync level; its falling edge starts a gain boost |
| chanChange | input | 1 | Channel-change request pulse |
| gainSel | input | 2 | Host-selected normal phase-detector gain |
| halfRate | input | 1 | 1 selects line-rate output, 0 selects twice line rate |
| trimWord | output | 6 | Oscillator frequency-correction word |
| pdEnable | output | 1 | Phase detector connected to the oscillator |
| pdGain | output | 2 | Phase-detector gain code, 2'b11 is maximum |
| notLocked | output | 1 | Coincidence failure flag |
| flybackMissing | output | 1 | No flyback seen during the last line |
| hOut | output | 1 | Selected twice-line-rate or line-rate pulse |

## Verification
The hardest state to reach is a locked loop whose trim counter is frozen. It needs sync pulses placed inside the four-count window at the end of the line and a calibration window that has already closed. The stimulus holds `hSync` high through whole lines so that lock is gained. It then feeds short lines, which would raise the trim if calibration were enabled, and checks that the trim does not move. It then issues a channel change and checks that exactly two steps happen. The coincidence window is probed at its edge by aligning the divider to count 0 and placing a single sync pulse at count 59, 60 and 63.

// File: rtl/lineosc_pkg.sv
package lineosc_pkg;

  // Command from the sequencer to the datapath
  typedef struct packed {
    logic trimUp;
    logic trimDown;
  } trimCmd_t;

  // Events reported by the datapath to the sequencer
  typedef struct packed {
    logic lineWrap;   // divider passes from last count to zero
    logic inWindow;   // divider count lies in the coincidence window
    logic refValid;   // reference pulse that closes a full measurement
    logic oscSlow;    // fewer ticks than one line
    logic oscFast;    // more ticks than one line
  } dpStatus_t;

  localparam logic [1:0] GAIN_MAX = 2'b11;

endpackage

// File: rtl/lineosc_datapath.sv
module lineosc_datapath
  import lineosc_pkg::*;
#(
  parameter int TRIM_W   = 6,
  parameter int DIV_LOG2 = 6,
  parameter int COIN_WIN = 4,
  parameter int MEAS_W   = DIV_LOG2 + 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              oscTick,
  input  logic              refLine,
  input  logic              halfRate,
  input  trimCmd_t          cmd,
  output dpStatus_t         stat,
  output logic [TRIM_W-1:0] trimWord,
  output logic              hOut
);

  localparam int DIV_N = 1 << DIV_LOG2;
  localparam logic [DIV_LOG2-1:0] DIV_LAST  = '1;
  localparam logic [DIV_LOG2-1:0] DIV_ONE   = DIV_LOG2'(1);
  localparam logic [DIV_LOG2-1:0] WIN_START = DIV_LOG2'(DIV_N - COIN_WIN);
  localparam logic [DIV_LOG2-2:0] HALF_LAST = '1;
  localparam logic [MEAS_W-1:0]   MEAS_MAX  = '1;
  localparam logic [MEAS_W-1:0]   MEAS_ONE  = MEAS_W'(1);
  localparam logic [MEAS_W:0]     LINE_TICKS = (MEAS_W+1)'(DIV_N);
  localparam logic [TRIM_W-1:0]   TRIM_MAX  = '1;
  localparam logic [TRIM_W-1:0]   TRIM_MID  = TRIM_W'(1 << (TRIM_W - 1));
  localparam logic [TRIM_W-1:0]   TRIM_ONE  = TRIM_W'(1);

  logic [DIV_LOG2-1:0] divCnt;
  logic [MEAS_W-1:0]   tickCnt;
  logic [MEAS_W:0]     measN;
  logic                measValid;
  logic                fhPulse, fh2Pulse;
  logic                wrapNow, halfNow;

  assign wrapNow = oscTick && (divCnt == DIV_LAST);
  assign halfNow = oscTick && (divCnt[DIV_LOG2-2:0] == HALF_LAST);
  assign measN   = {1'b0, tickCnt} + {{MEAS_W{1'b0}}, oscTick};

  // Divider and line pulses
  always_ff @(posedge clk) begin
    if (rst) begin
      divCnt   <= '0;
      fhPulse  <= 1'b0;
      fh2Pulse <= 1'b0;
    end else begin
      if (oscTick) divCnt <= divCnt + DIV_ONE;
      fhPulse  <= wrapNow;
      fh2Pulse <= halfNow;
    end
  end

  // Output rate variant
  assign hOut = halfRate ? fhPulse : fh2Pulse;

  // Tick measurement between reference pulses
  always_ff @(posedge clk) begin
    if (rst) begin
      tickCnt   <= '0;
      measValid <= 1'b0;
    end else if (refLine) begin
      tickCnt   <= '0;
      measValid <= 1'b1;
    end else if (oscTick && tickCnt != MEAS_MAX) begin
      tickCnt <= tickCnt + MEAS_ONE;
    end
  end

  // Saturating trim counter
  always_ff @(posedge clk) begin
    if (rst) begin
      trimWord <= TRIM_MID;
    end else if (cmd.trimUp && trimWord != TRIM_MAX) begin
      trimWord <= trimWord + TRIM_ONE;
    end else if (cmd.trimDown && trimWord != '0) begin
      trimWord <= trimWord - TRIM_ONE;
    end
  end

  always_comb begin
    stat.lineWrap = wrapNow;
    stat.inWindow = (divCnt >= WIN_START);
    stat.refValid = refLine && measValid;
    stat.oscSlow  = (measN < LINE_TICKS);
    stat.oscFast  = (measN > LINE_TICKS);
  end

endmodule

// File: rtl/lineosc_control.sv
module lineosc_control
  import lineosc_pkg::*;
#(
  parameter int CAL_LINES   = 2,
  parameter int BOOST_LINES = 11
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      refLine,
  input  logic      hSync,
  input  logic      flyback,
  input  logic      vSync,
  input  logic      chanChange,
  input  logic [1:0] gainSel,
  input  dpStatus_t stat,
  output trimCmd_t  cmd,
  output logic      pdEnable,
  output logic [1:0] pdGain,
  output logic      notLocked,
  output logic      flybackMissing
);

  localparam int CAL_W   = $clog2(CAL_LINES + 1);
  localparam int BOOST_W = $clog2(BOOST_LINES + 1);
  localparam logic [CAL_W-1:0]   CAL_INIT   = CAL_W'(CAL_LINES);
  localparam logic [CAL_W-1:0]   CAL_ONE    = CAL_W'(1);
  localparam logic [BOOST_W-1:0] BOOST_INIT = BOOST_W'(BOOST_LINES);
  localparam logic [BOOST_W-1:0] BOOST_ONE  = BOOST_W'(1);

  logic [CAL_W-1:0]   calLeft;
  logic [BOOST_W-1:0] boostLeft;
  logic syncSeen, flySeen, vPrev;
  logic syncHit, calEn;

  assign syncHit = hSync && stat.inWindow;
  assign calEn   = (calLeft != '0) || notLocked;

  always_ff @(posedge clk) begin
    if (rst) begin
      calLeft        <= CAL_INIT;
      boostLeft      <= '0;
      notLocked      <= 1'b1;
      flybackMissing <= 1'b0;
      syncSeen       <= 1'b0;
      flySeen        <= 1'b0;
      vPrev          <= 1'b0;
    end else begin
      vPrev <= vSync;

      if (chanChange) calLeft <= CAL_INIT;
      else if (refLine && calLeft != '0) calLeft <= calLeft - CAL_ONE;

      if (vPrev && !vSync) boostLeft <= BOOST_INIT;
      else if (refLine && boostLeft != '0) boostLeft <= boostLeft - BOOST_ONE;

      if (stat.lineWrap) begin
        notLocked      <= !(syncSeen || syncHit);
        flybackMissing <= !(flySeen || flyback);
        syncSeen       <= 1'b0;
        flySeen        <= 1'b0;
      end else begin
        if (syncHit) syncSeen <= 1'b1;
        if (flyback) flySeen  <= 1'b1;
      end
    end
  end

  always_comb begin
    cmd.trimUp   = stat.refValid && stat.oscSlow && calEn;
    cmd.trimDown = stat.refValid && stat.oscFast && calEn;
  end

  assign pdEnable = (calLeft == '0);
  assign pdGain   = (boostLeft != '0) ? GAIN_MAX : gainSel;

endmodule

// File: rtl/lineosc_top.sv
module lineosc_top
  import lineosc_pkg::*;
#(
  parameter int TRIM_W      = 6,
  parameter int DIV_LOG2    = 6,
  parameter int COIN_WIN    = 4,
  parameter int CAL_LINES   = 2,
  parameter int BOOST_LINES = 11
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              oscTick,
  input  logic              refLine,
  input  logic              hSync,
  input  logic              flyback,
  input  logic              vSync,
  input  logic              chanChange,
  input  logic [1:0]        gainSel,
  input  logic              halfRate,
  output logic [TRIM_W-1:0] trimWord,
  output logic              pdEnable,
  output logic [1:0]        pdGain,
  output logic              notLocked,
  output logic              flybackMissing,
  output logic              hOut
);

  trimCmd_t  cmd;
  dpStatus_t stat;

  lineosc_datapath #(
    .TRIM_W(TRIM_W), .DIV_LOG2(DIV_LOG2), .COIN_WIN(COIN_WIN)
  ) u_dp (
    .clk(clk), .rst(rst), .oscTick(oscTick), .refLine(refLine),
    .halfRate(halfRate), .cmd(cmd), .stat(stat),
    .trimWord(trimWord), .hOut(hOut)
  );

  lineosc_control #(
    .CAL_LINES(CAL_LINES), .BOOST_LINES(BOOST_LINES)
  ) u_ctl (
    .clk(clk), .rst(rst), .refLine(refLine), .hSync(hSync),
    .flyback(flyback), .vSync(vSync), .chanChange(chanChange),
    .gainSel(gainSel), .stat(stat), .cmd(cmd), .pdEnable(pdEnable),
    .pdGain(pdGain), .notLocked(notLocked), .flybackMissing(flybackMissing)
  );

endmodule

// File: rtl/lineosc_checker.sv
module lineosc_checker #(
  parameter int TRIM_W = 6
) (
  input logic              clk,
  input logic              rst,
  input logic              vSync,
  input logic              chanChange,
  input logic [TRIM_W-1:0] trimWord,
  input logic              pdEnable,
  input logic [1:0]        pdGain,
  input logic              notLocked,
  input logic              hOut
);

  localparam logic [TRIM_W-1:0] TRIM_MAX = '1;

  // R3: trim moves by at most one code per cycle
  a_r3_single_step: assert property (@(posedge clk) disable iff (rst)
    (trimWord == $past(trimWord)) || (trimWord == $past(trimWord) + 1'b1) ||
    (trimWord == $past(trimWord) - 1'b1));

  // R4: no wrap from the top code to zero
  a_r4_no_wrap_top: assert property (@(posedge clk) disable iff (rst)
    (trimWord == TRIM_MAX) |=> (trimWord != '0));

  // R4: no wrap from zero to the top code
  a_r4_no_wrap_bottom: assert property (@(posedge clk) disable iff (rst)
    (trimWord == '0) |=> (trimWord != TRIM_MAX));

  // R6: channel change disconnects the phase detector
  a_r6_chan_cut: assert property (@(posedge clk) disable iff (rst)
    chanChange |=> !pdEnable);

  // R7: trim changes only while calibrating or out of lock
  a_r7_frozen_when_locked: assert property (@(posedge clk) disable iff (rst)
    !$stable(trimWord) |-> $past(!pdEnable || notLocked));

  // R10: end of vertical sync forces maximum gain
  a_r10_boost_start: assert property (@(posedge clk) disable iff (rst)
    $fell(vSync) |=> (pdGain == 2'b11));

  // R2: output pulses last one cycle
  a_r2_single_pulse: assert property (@(posedge clk) disable iff (rst)
    hOut |=> !hOut);

endmodule

bind lineosc_top lineosc_checker #(.TRIM_W(TRIM_W)) u_chk (
  .clk(clk), .rst(rst), .vSync(vSync), .chanChange(chanChange),
  .trimWord(trimWord), .pdEnable(pdEnable), .pdGain(pdGain),
  .notLocked(notLocked), .hOut(hOut)
);

// File: tb/lineosc_top_test.sv
module lineosc_top_test;

  localparam time CLK_PERIOD = 10ns;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic oscTick = 1'b0, refLine = 1'b0, hSync = 1'b0, flyback = 1'b0;
  logic vSync = 1'b0, chanChange = 1'b0, halfRate = 1'b0;
  logic [1:0] gainSel = 2'b00;
  logic [5:0] trimWord;
  logic pdEnable, notLocked, flybackMissing, hOut;
  logic [1:0] pdGain;

  int nChecks = 0;
  int nErr = 0;
  int phase = 0;     // divider count tracked in the bench
  int hsMode = -1;   // -1 never, 64 always, else the count that gets sync
  bit fbOn = 1'b0;
  int prevN = 0;
  bit bValid = 1'b0;
  int expTrim = 32;
  int pulses;

  always #(CLK_PERIOD / 2) clk = ~clk;

  lineosc_top uut (
    .clk(clk), .rst(rst), .oscTick(oscTick), .refLine(refLine),
    .hSync(hSync), .flyback(flyback), .vSync(vSync),
    .chanChange(chanChange), .gainSel(gainSel), .halfRate(halfRate),
    .trimWord(trimWord), .pdEnable(pdEnable), .pdGain(pdGain),
    .notLocked(notLocked), .flybackMissing(flybackMissing), .hOut(hOut)
  );

  task automatic check(input string tag, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nErr++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // One clock: inputs set now, captured at the next rising edge,
  // outputs read back after the following falling edge.
  task automatic cyc(input logic t, input logic r);
    oscTick = t;
    refLine = r;
    hSync   = (hsMode == 64) || (hsMode == phase);
    flyback = fbOn;
    @(negedge clk);
    if (t) phase = (phase + 1) % 64;
    oscTick = 1'b0;
    refLine = 1'b0;
    hSync   = 1'b0;
    flyback = 1'b0;
  endtask

  // Reference pulse, then n oscillator ticks; models the trim step
  task automatic line(input int n, input bit en);
    cyc(1'b0, 1'b1);
    if (bValid && en) begin
      if (prevN < 64 && expTrim < 63) expTrim++;
      else if (prevN > 64 && expTrim > 0) expTrim--;
    end
    bValid = 1'b1;
    prevN = n;
    check("R3 R4 trim step", int'(trimWord), expTrim);
    for (int i = 0; i < n; i++) cyc(1'b1, 1'b0);
  endtask

  // Bring the divider to count 0, then run one full line of ticks
  task automatic alignedLine();
    while (phase != 0) cyc(1'b1, 1'b0);
    for (int i = 0; i < 64; i++) cyc(1'b1, 1'b0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nErr++;
    $display("FAIL watchdog expired (all requirements)");
    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErr);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R12 reset state
    check("R12 trim reset", int'(trimWord), 32);
    check("R12 pdEnable reset", int'(pdEnable), 0);
    check("R12 notLocked reset", int'(notLocked), 1);
    check("R12 flybackMissing reset", int'(flybackMissing), 0);
    check("R12 hOut reset", int'(hOut), 0);
    check("R12 gain reset", int'(pdGain), 0);

    // R1 R2: twice line rate, 128 ticks give 4 pulses
    halfRate = 1'b0;
    pulses = 0;
    for (int i = 0; i < 128; i++) begin
      cyc(1'b1, 1'b0);
      if (hOut) pulses++;
    end
    check("R2 twice-rate pulse count", pulses, 4);

    // R1 R2: line rate, nothing until the 64th tick
    halfRate = 1'b1;
    pulses = 0;
    for (int i = 0; i < 63; i++) begin
      cyc(1'b1, 1'b0);
      if (hOut) pulses++;
    end
    check("R1 no pulse before 64th tick", pulses, 0);
    cyc(1'b1, 1'b0);
    check("R1 pulse after 64th tick", int'(hOut), 1);
    cyc(1'b0, 1'b0);
    check("R2 pulse lasts one cycle", int'(hOut), 0);

    // R3 R4 R5: slow oscillator, unlocked, saturate upward
    hsMode = -1;
    line(60, 1'b1);
    check("R5 pdEnable after one ref", int'(pdEnable), 0);
    line(60, 1'b1);
    check("R5 pdEnable after two refs", int'(pdEnable), 1);
    for (int i = 0; i < 38; i++) line(60, 1'b1);
    check("R4 saturate high", int'(trimWord), 63);
    for (int i = 0; i < 3; i++) line(64, 1'b1);   // R3 hold on equal
    for (int i = 0; i < 70; i++) line(70, 1'b1);  // R3 down, R4 low stop
    check("R4 saturate low", int'(trimWord), 0);

    // R7 R8: gain lock, then short lines must not move the trim
    hsMode = 64;
    line(64, 1'b1);
    line(64, 1'b0);
    check("R8 locked with sync in window", int'(notLocked), 0);
    for (int i = 0; i < 3; i++) line(60, 1'b0);
    check("R7 trim frozen while locked", int'(trimWord), 0);

    // R6: channel change gives exactly two steps
    chanChange = 1'b1;
    cyc(1'b0, 1'b0);
    chanChange = 1'b0;
    check("R6 pdEnable cut", int'(pdEnable), 0);
    line(60, 1'b1);
    line(60, 1'b1);
    check("R6 pdEnable back", int'(pdEnable), 1);
    line(60, 1'b0);
    check("R6 two steps only", int'(trimWord), 2);

    // R8: coincidence window edges
    hsMode = 60; alignedLine();
    check("R8 sync at 60 in window", int'(notLocked), 0);
    hsMode = 59; alignedLine();
    check("R8 sync at 59 outside", int'(notLocked), 1);
    hsMode = 63; alignedLine();
    check("R8 sync at 63 in window", int'(notLocked), 0);
    hsMode = 10; alignedLine();
    check("R8 sync at 10 outside", int'(notLocked), 1);
    hsMode = -1;

    // R11: flyback missing
    fbOn = 1'b0; alignedLine();
    check("R11 no flyback", int'(flybackMissing), 1);
    fbOn = 1'b1; alignedLine();
    check("R11 flyback present", int'(flybackMissing), 0);
    fbOn = 1'b0;

    // R9: selected gain
    for (int g = 0; g < 4; g++) begin
      gainSel = 2'(g);
      cyc(1'b0, 1'b0);
      check("R9 gain follows select", int'(pdGain), g);
    end

    // R10: boost for 11 lines after vertical sync ends
    gainSel = 2'b01;
    vSync = 1'b1;
    repeat (3) cyc(1'b0, 1'b0);
    check("R10 no boost during vsync", int'(pdGain), 1);
    vSync = 1'b0;
    cyc(1'b0, 1'b0);
    check("R10 boost starts", int'(pdGain), 3);
    for (int i = 0; i < 10; i++) begin
      cyc(1'b0, 1'b1);
      cyc(1'b0, 1'b0);
    end
    check("R10 boost held after 10 refs", int'(pdGain), 3);
    cyc(1'b0, 1'b1);
    check("R10 boost ends after 11 refs", int'(pdGain), 1);

    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErr);
    $finish;
  end

endmodule